// File: doc/BRIEF.md
# Bit-Sliced 32-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 32-bit datapath. The core is a ripple chain of identical one-bit cells. Each cell can invert either operand, forms the AND, the OR and a full-adder sum of its bits, and picks one of these, or a fed-back "less" bit, through a small multiplexer tree. A 4-bit operation code drives the unit. Its two upper bits invert operand A and operand B. Its two lower bits pick the cell output. This split gives addition, subtraction, NOR, NAND and signed compare from the same chain.

Exclusive-or and the two shifts do not fit the cell structure. They are built beside the chain and merged at the output. The unit holds no state: results, the zero flag, the carry-out and the overflow flag follow the inputs within the same cycle. It is meant to sit in the execute stage of a simple processor core.

Top module: `bs_alu`

## Requirements
- R1: Code 4'b0000 gives A & B and code 4'b0001 gives A | B.
- R2: Code 4'b0010 gives (A + B) mod 2^32, and carry_o is the carry out of bit 31 of that sum.
- R3: Code 4'b0110 gives (A - B) mod 2^32, and carry_o is the carry out of bit 31 of A + ~B + 1 (1 when no borrow occurs).
- R4: For codes 4'b0010 and 4'b0110, ovf_o is 1 exactly when the signed result does not fit in 32 bits.
- R5: Code 4'b0111 gives 1 in result bit 0 when A < B as signed two's-complement numbers, else 0, and all of bits 31..1 are 0. The comparison is correct even when A - B overflows.
- R6: Code 4'b1100 gives ~(A | B) and code 4'b1101 gives ~(A & B).
- R7: Code 4'b0011 gives A ^ B.
- R8: Code 4'b1000 gives A shifted left by B[4:0], filling with zeros; bits 31..5 of B have no effect.
- R9: Code 4'b1001 gives A shifted right by B[4:0], filling with copies of A[31]; bits 31..5 of B have no effect.
- R10: For every code other than 4'b0010 and 4'b0110, both carry_o and ovf_o are 0.
- R11: Each of the six codes not listed in R1 to R9 (0100, 0101, 1010, 1011, 1110, 1111) gives a result of 0.
- R12: zero_o is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 32 | First operand (A) |
| src_b_i | input | 32 | Second operand (B); its low 5 bits are the shift amount |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry out of the most significant cell for add and subtract |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
Every one of the 16 codes is applied to a set of directed operand pairs. The pairs at the signed extremes (0x7FFFFFFF against 0x80000000, and -1 against 1) separate a true signed compare and a correct overflow from a compare that only reads the sign of the difference. Equal operands and all-ones operands exercise the zero flag and the full carry chain. Shift amounts of 0, 31 and 32 or above show that only B[4:0] is used and that the right shift fills with the sign bit. Random operands from a fixed seed, run under every code, check the logical, arithmetic and shift paths in bulk. The unused codes are checked for a zero result and quiet flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_W  = 32;
    localparam int CODE_W = 4;

    // Operation codes: bit 3 inverts A, bit 2 inverts B, bits 1:0 pick the cell output
    typedef enum logic [CODE_W-1:0] {
        OPC_AND  = 4'b0000,
        OPC_OR   = 4'b0001,
        OPC_ADD  = 4'b0010,
        OPC_XOR  = 4'b0011,
        OPC_SUB  = 4'b0110,
        OPC_SLT  = 4'b0111,
        OPC_SLL  = 4'b1000,
        OPC_SRA  = 4'b1001,
        OPC_NOR  = 4'b1100,
        OPC_NAND = 4'b1101
    } alu_code_e;

    // Output picked inside each one-bit cell
    typedef enum logic [1:0] {
        CELL_AND  = 2'b00,
        CELL_OR   = 2'b01,
        CELL_SUM  = 2'b10,
        CELL_LESS = 2'b11
    } cell_pick_e;

    // Source of the final result
    typedef enum logic [2:0] {
        OUT_CHAIN,
        OUT_XOR,
        OUT_SHL,
        OUT_SHR,
        OUT_NONE
    } out_src_e;

    typedef struct packed {
        logic       inv_a;
        logic       inv_b;
        cell_pick_e pick;
        out_src_e   src;
        logic       arith;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input logic [CODE_W-1:0] code);
        alu_ctl_t c;
        c.inv_a = code[3];
        c.inv_b = code[2];
        c.pick  = cell_pick_e'(code[1:0]);
        c.arith = 1'b0;
        case (code)
            OPC_AND, OPC_OR, OPC_SLT,
            OPC_NOR, OPC_NAND: c.src = OUT_CHAIN;
            OPC_ADD, OPC_SUB: begin
                c.src   = OUT_CHAIN;
                c.arith = 1'b1;
            end
            OPC_XOR: c.src = OUT_XOR;
            OPC_SLL: c.src = OUT_SHL;
            OPC_SRA: c.src = OUT_SHR;
            default: c.src = OUT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_mux2.sv
module alu_mux2 #(
    parameter int W = 1
) (
    input  logic [W-1:0] d0_i,
    input  logic [W-1:0] d1_i,
    input  logic         sel_i,
    output logic [W-1:0] y_o
);
    assign y_o = sel_i ? d1_i : d0_i;
endmodule

// File: rtl/alu_mux4.sv
module alu_mux4 #(
    parameter int W = 1
) (
    input  logic [W-1:0] d0_i,
    input  logic [W-1:0] d1_i,
    input  logic [W-1:0] d2_i,
    input  logic [W-1:0] d3_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        case (sel_i)
            2'd0:    y_o = d0_i;
            2'd1:    y_o = d1_i;
            2'd2:    y_o = d2_i;
            default: y_o = d3_i;
        endcase
    end
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell (
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic [1:0] pick_i,
    input  logic       cin_i,
    input  logic       less_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);
    logic a_eff;
    logic b_eff;
    logic and_b;
    logic or_b;

    alu_mux2 #(.W(1)) u_inv_a (.d0_i(a_i), .d1_i(~a_i), .sel_i(inv_a_i), .y_o(a_eff));
    alu_mux2 #(.W(1)) u_inv_b (.d0_i(b_i), .d1_i(~b_i), .sel_i(inv_b_i), .y_o(b_eff));

    assign and_b  = a_eff & b_eff;
    assign or_b   = a_eff | b_eff;
    assign sum_o  = a_eff ^ b_eff ^ cin_i;
    assign cout_o = (a_eff & b_eff) | (cin_i & (a_eff ^ b_eff));

    alu_mux4 #(.W(1)) u_pick (
        .d0_i (and_b),
        .d1_i (or_b),
        .d2_i (sum_o),
        .d3_i (less_i),
        .sel_i(pick_i),
        .y_o  (res_o)
    );
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W         = 32,
    parameter bit SHIFT_SRA = 1'b0,
    localparam int AMT_W    = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     data_o
);
    logic [AMT_W:0][W-1:0] stage;

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        logic [W-1:0] moved;
        if (SHIFT_SRA) begin : g_right
            assign moved = W'($signed(stage[s]) >>> (2 ** s));
        end else begin : g_left
            assign moved = stage[s] << (2 ** s);
        end
        assign stage[s+1] = amt_i[s] ? moved : stage[s];
    end

    assign data_o = stage[AMT_W];
endmodule

// File: rtl/bs_alu.sv
module bs_alu
    import alu_pkg::*;
#(
    parameter int W      = ALU_W,
    localparam int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]      src_a_i,
    input  logic [W-1:0]      src_b_i,
    input  logic [CODE_W-1:0] op_i,
    output logic [W-1:0]      result_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              ovf_o
);
    alu_ctl_t     ctl;
    logic [W-1:0] chain_res;
    logic         set_less;
    logic         ovf_raw;
    logic [W-1:0] shl_res;
    logic [W-1:0] shr_res;

    assign ctl = decode_op(op_i);

    // Ripple chain of one-bit cells; subtraction forces a carry-in of one
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic cin;
        logic cout;
        logic sum;
        logic res;
        logic less;

        if (i == 0) begin : g_lsb
            assign cin  = ctl.inv_b;
            assign less = set_less;
        end else begin : g_upper
            assign cin  = g_cell[i-1].cout;
            assign less = 1'b0;
        end

        alu_bit_cell u_cell (
            .a_i    (src_a_i[i]),
            .b_i    (src_b_i[i]),
            .inv_a_i(ctl.inv_a),
            .inv_b_i(ctl.inv_b),
            .pick_i (ctl.pick),
            .cin_i  (cin),
            .less_i (less),
            .res_o  (res),
            .sum_o  (sum),
            .cout_o (cout)
        );

        assign chain_res[i] = res;
    end

    // Signed overflow from the carries around the top cell; true sign of A-B fed back
    assign ovf_raw  = g_cell[W-1].cin ^ g_cell[W-1].cout;
    assign set_less = g_cell[W-1].sum ^ ovf_raw;

    alu_shifter #(.W(W), .SHIFT_SRA(1'b0)) u_shl (
        .data_i(src_a_i),
        .amt_i (src_b_i[AMT_W-1:0]),
        .data_o(shl_res)
    );

    alu_shifter #(.W(W), .SHIFT_SRA(1'b1)) u_shr (
        .data_i(src_a_i),
        .amt_i (src_b_i[AMT_W-1:0]),
        .data_o(shr_res)
    );

    always_comb begin
        case (ctl.src)
            OUT_CHAIN: result_o = chain_res;
            OUT_XOR:   result_o = src_a_i ^ src_b_i;
            OUT_SHL:   result_o = shl_res;
            OUT_SHR:   result_o = shr_res;
            default:   result_o = '0;
        endcase
    end

    assign zero_o  = ~|result_o;
    assign carry_o = ctl.arith & g_cell[W-1].cout;
    assign ovf_o   = ctl.arith & ovf_raw;

endmodule

// File: rtl/bs_alu_chk.sv
module bs_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] src_a_i,
    input logic [W-1:0] src_b_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] result_o,
    input logic         zero_o,
    input logic         carry_o,
    input logic         ovf_o
);
    always_comb begin
        // R12
        zero_flag_chk: assert (zero_o == (result_o == '0));

        if (op_i == 4'b0111) begin
            // R5
            slt_upper_chk: assert (result_o[W-1:1] == '0);
        end

        if (op_i != 4'b0010 && op_i != 4'b0110) begin
            // R10
            quiet_flags_chk: assert (!carry_o && !ovf_o);
        end

        if (op_i == 4'b0100 || op_i == 4'b0101 || op_i == 4'b1010 ||
            op_i == 4'b1011 || op_i == 4'b1110 || op_i == 4'b1111) begin
            // R11
            unused_zero_chk: assert (result_o == '0);
        end

        if (op_i == 4'b0010) begin
            // R4
            add_ovf_chk: assert (ovf_o == ((src_a_i[W-1] == src_b_i[W-1]) &&
                                           (result_o[W-1] != src_a_i[W-1])));
            // R2
            add_sum_chk: assert ({carry_o, result_o} ==
                                 ({1'b0, src_a_i} + {1'b0, src_b_i}));
        end

        if (op_i == 4'b0110) begin
            // R4
            sub_ovf_chk: assert (ovf_o == ((src_a_i[W-1] != src_b_i[W-1]) &&
                                           (result_o[W-1] != src_a_i[W-1])));
        end
    end
endmodule

bind bs_alu bs_alu_chk #(.W(W)) u_chk (
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .op_i    (op_i),
    .result_o(result_o),
    .zero_o  (zero_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/tb_bs_alu.sv
module tb_bs_alu;

    logic        clk = 1'b0;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  op;
    logic [31:0] result;
    logic        zero;
    logic        carry;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bs_alu dut (
        .src_a_i (a),
        .src_b_i (b),
        .op_i    (op),
        .result_o(result),
        .zero_o  (zero),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    function automatic string req_tag(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0001: return "R1";
            4'b0010:          return "R2";
            4'b0110:          return "R3";
            4'b0111:          return "R5";
            4'b1100, 4'b1101: return "R6";
            4'b0011:          return "R7";
            4'b1000:          return "R8";
            4'b1001:          return "R9";
            default:          return "R11";
        endcase
    endfunction

    // Reference model: {carry, ovf, result}
    function automatic logic [33:0] ref_model(input logic [31:0] x,
                                              input logic [31:0] y,
                                              input logic [3:0]  c);
        logic [32:0] wide;
        logic [31:0] r;
        logic        co;
        logic        ov;
        co = 1'b0;
        ov = 1'b0;
        r  = '0;
        case (c)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b0010: begin // R2, R4
                wide = {1'b0, x} + {1'b0, y};
                r  = wide[31:0];
                co = wide[32];
                ov = (x[31] == y[31]) && (r[31] != x[31]);
            end
            4'b0110: begin // R3, R4
                wide = {1'b0, x} + {1'b0, ~y} + 33'd1;
                r  = wide[31:0];
                co = wide[32];
                ov = (x[31] != y[31]) && (r[31] != x[31]);
            end
            4'b0111: r = {31'd0, ($signed(x) < $signed(y))};
            4'b1100: r = ~(x | y);
            4'b1101: r = ~(x & y);
            4'b0011: r = x ^ y;
            4'b1000: r = x << y[4:0];
            4'b1001: r = $signed(x) >>> y[4:0];
            default: r = '0;
        endcase
        return {co, ov, r};
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] y,
                         input logic [3:0] c);
        logic [33:0] exp;
        logic        exp_zero;
        string       tag;
        @(posedge clk);
        a  = x;
        b  = y;
        op = c;
        @(negedge clk);
        exp      = ref_model(x, y, c);
        exp_zero = (exp[31:0] == 32'd0);
        tag      = req_tag(c);
        if ((exp[33] || exp[32]) == 1'b0 && (carry || ovf))
            tag = {tag, "/R10"};
        if (zero != exp_zero)
            tag = {tag, "/R12"};
        checks++;
        if (result !== exp[31:0] || carry !== exp[33] ||
            ovf !== exp[32] || zero !== exp_zero) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: got r=%h c=%b v=%b z=%b, expected r=%h c=%b v=%b z=%b",
                     tag, c, x, y, result, carry, ovf, zero,
                     exp[31:0], exp[33], exp[32], exp_zero);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no end, expected end of run");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] da [10];
        logic [31:0] db [10];
        a  = '0;
        b  = '0;
        op = '0;
        void'($urandom(32'd20240517));

        // Idle state: zero operands under AND give zero result, zero flag set (R12)
        @(negedge clk);
        checks++;
        if (result !== 32'd0 || zero !== 1'b1 || carry !== 1'b0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R12 idle: got r=%h z=%b c=%b v=%b, expected r=0 z=1 c=0 v=0",
                     result, zero, carry, ovf);
        end

        da[0] = 32'h0000_0000; db[0] = 32'h0000_0000;
        da[1] = 32'hFFFF_FFFF; db[1] = 32'h0000_0001;
        da[2] = 32'h7FFF_FFFF; db[2] = 32'h0000_0001;
        da[3] = 32'h8000_0000; db[3] = 32'h0000_0001;
        da[4] = 32'h8000_0000; db[4] = 32'h7FFF_FFFF;
        da[5] = 32'h7FFF_FFFF; db[5] = 32'h8000_0000;
        da[6] = 32'h1234_5678; db[6] = 32'h0000_0020; // R8/R9: amount 32 acts as 0
        da[7] = 32'hF0F0_F0F0; db[7] = 32'hFFFF_FFFF; // amount 31
        da[8] = 32'h0000_0005; db[8] = 32'h0000_0005;
        da[9] = 32'h8765_4321; db[9] = 32'hABCD_EF04; // upper B bits ignored

        // Directed corners under every code (R1..R12)
        for (int i = 0; i < 10; i++)
            for (int c = 0; c < 16; c++)
                apply(da[i], db[i], 4'(c));

        // Random operands under every code
        for (int c = 0; c < 16; c++)
            for (int n = 0; n < 200; n++)
                apply($urandom, $urandom, 4'(c));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule